// File: doc/BRIEF.md
# Partial-Scan Test Sequencer

This block drives a circuit in which only some of the flip-flops are stitched into a scan chain. The scanned flip-flops and the unscanned flip-flops run from two separate clock enables. The sequencer owns the test-control line that chooses between shifting and functional capture. It also produces both clock enables, the serial data fed into the chain and a capture strobe. It samples the serial output of the chain and compares it against expected data.

A run starts with a single-cycle `start` pulse. The run begins with a chain-integrity shift whose bits repeat 0,0,1,1 and which lasts four shifts more than the chain length. The test vectors follow, each loaded by a full chain shift and then applied by one capture clock. While a vector is loaded, the response captured by the previous vector is unloaded. A final shift empties the chain after the last capture. Vectors and expected responses come from two small internal ROMs whose contents are computed from the parameters.

The test-control line only moves in a cycle where both enables are low. One idle cycle therefore separates every switch between shifting and capture. These idle cycles are not clock pulses. The number of pulsed cycles in a run is fixed by the chain length and the vector count.

Top module: `pscan_seq`

## Requirements
- R1: After reset every output is low. In a shift cycle `scan_clk_en`=1, `sys_clk_en`=0 and `test_mode`=1. In a capture cycle `scan_clk_en`=1, `sys_clk_en`=1, `capture_stb`=1 and `test_mode`=0. No other cycle raises an enable.
- R2: `test_mode` changes value only in a cycle where `scan_clk_en` and `sys_clk_en` are both 0.
- R3: The first CHAIN_LEN+4 shifts after start form the integrity pattern: at shift k (from 0), `chain_si` equals bit 1 of k, giving 0,0,1,1 repeated.
- R4: Next, each vector v (0 to NUM_VEC-1) is loaded by CHAIN_LEN shifts, sending bit j of its word at shift j, and is then applied by one capture cycle. The word is the low CHAIN_LEN bits of ((v+1)·0x9E3779B1 mod 2^32) XOR 0xA5A5A5A5.
- R5: From start to done the number of cycles with an enable high is exactly (NUM_VEC+2)·CHAIN_LEN + NUM_VEC + 4.
- R6: After the last capture, CHAIN_LEN unload shifts follow with `chain_si`=0. `done` rises two cycles after the last unload shift.
- R7: `chain_so` is compared on every shift except the first CHAIN_LEN integrity shifts. At integrity shift k ≥ CHAIN_LEN the expected bit is bit 1 of k−CHAIN_LEN. At load shift j of vector 0 the expected bit is bit 1 of j. At shift j of the load of vector v ≥ 1, or of the final unload, the expected bit is bit j of the complement of the previously applied vector's word, XORed with that vector's index.
- R8: When `done` rises, `mismatch` is 1 exactly when at least one compared bit disagreed. A wrong bit in the first CHAIN_LEN integrity shifts, or during a capture cycle, does not set it.
- R9: `done` and `mismatch` hold until the next accepted `start`. One cycle after that start, both are 0.
- R10: A `start` pulse while a run is in progress is ignored: the run keeps its exact sequence and pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle or done |
| chain_so | input | 1 | Serial output of the last scanned flip-flop |
| test_mode | output | 1 | 1 selects shift path, 0 selects functional capture |
| scan_clk_en | output | 1 | Clock enable of the scanned flip-flops |
| sys_clk_en | output | 1 | Clock enable of the unscanned flip-flops |
| chain_si | output | 1 | Serial data into the chain |
| capture_stb | output | 1 | Marks the capture cycle |
| done | output | 1 | Run finished, held until next start |
| mismatch | output | 1 | Any compared bit disagreed in the finished run |

## Verification
The assertions assume that `chain_so` comes straight from the last scanned flip-flop. They also assume it moves only on an edge where `scan_clk_en` is high, and that the attached chain is exactly CHAIN_LEN long. The bench models such a chain, with an unscanned capture counter that is cleared with each start, so that clean runs match the stored responses. Faults enter only by inverting `chain_so` in one chosen pulse cycle, chosen at random or placed on the unchecked window, on a capture cycle and on the final shift. This keeps the chain model itself in step with the stored data.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ENTER,
    S_INTEG,
    S_LOAD,
    S_TO_CAP,
    S_CAP,
    S_TO_SHIFT,
    S_UNLOAD,
    S_EXIT,
    S_DONE
  } seq_state_e;

  localparam int ROM_STIM = 0;
  localparam int ROM_RESP = 1;

  // Stimulus word applied by vector idx (caller truncates to chain length).
  function automatic logic [31:0] stim_word(input int unsigned idx);
    logic [31:0] prod;
    prod = 32'(idx + 1) * 32'h9E37_79B1;
    return prod ^ 32'hA5A5_A5A5;
  endfunction

  // Response captured by the chain for vector idx: inverted stimulus mixed
  // with the count of captures made before it by the unscanned state.
  function automatic logic [31:0] resp_word(input int unsigned idx);
    return ~stim_word(idx) ^ 32'(idx);
  endfunction

endpackage

// File: rtl/pscan_rom.sv
module pscan_rom #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 6,
  parameter int KIND  = 0,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  output logic [WIDTH-1:0] data
);
  import pscan_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      if (KIND == ROM_STIM) mem[i] = WIDTH'(stim_word(i));
      else                  mem[i] = WIDTH'(resp_word(i));
    end
  end

  // Registered read, no reset: maps onto a synchronous block memory.
  always_ff @(posedge clk) begin
    data <= mem[addr];
  end

endmodule

// File: rtl/pscan_ctrl.sv
module pscan_ctrl #(
  parameter int CHAIN_LEN = 12,
  parameter int NUM_VEC   = 6,
  localparam int AW       = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CHAIN_LEN-1:0] stim_data,
  input  logic [CHAIN_LEN-1:0] resp_data,
  output logic [AW-1:0]        stim_addr,
  output logic [AW-1:0]        resp_addr,
  output logic                 test_mode,
  output logic                 scan_clk_en,
  output logic                 sys_clk_en,
  output logic                 chain_si,
  output logic                 capture_stb,
  output logic                 cmp_en,
  output logic                 cmp_bit,
  output logic                 run_clr,
  output logic                 publish,
  output logic                 done
);
  import pscan_pkg::*;

  localparam int CW     = $clog2(CHAIN_LEN + 4);
  localparam int VW     = $clog2(NUM_VEC + 1);
  localparam int IW     = $clog2(CHAIN_LEN);
  localparam int BUDGET = (NUM_VEC + 2) * CHAIN_LEN + NUM_VEC + 4;
  localparam int PCW    = $clog2(BUDGET + 1);
  localparam logic [1:0] LMOD = 2'(CHAIN_LEN % 4);

  seq_state_e     st, st_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic [VW-1:0]  vec, vec_n;
  logic [VW-1:0]  vec_cl, vec_pr;

  logic mode_n, sce_n, sys_n, si_n, cap_n, chk_n, exp_n;
  logic [1:0] integ_ph;

  // ROM addressing: current vector for stimulus, previous one for response.
  always_comb begin
    vec_cl    = (vec >= VW'(NUM_VEC)) ? VW'(NUM_VEC - 1) : vec;
    vec_pr    = (vec == '0) ? '0 : vec - 1'b1;
    stim_addr = AW'(vec_cl);
    resp_addr = AW'(vec_pr);
  end

  assign run_clr = start && (st == S_IDLE || st == S_DONE);
  assign publish = (st == S_EXIT);

  // Next phase
  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    vec_n = vec;
    case (st)
      S_IDLE, S_DONE: begin
        if (start) begin
          st_n  = S_ENTER;
          cnt_n = '0;
          vec_n = '0;
        end
      end
      S_ENTER: begin
        st_n  = S_INTEG;
        cnt_n = '0;
      end
      S_INTEG: begin
        if (cnt == CW'(CHAIN_LEN + 3)) begin
          st_n  = S_LOAD;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      S_LOAD: begin
        if (cnt == CW'(CHAIN_LEN - 1)) st_n = S_TO_CAP;
        else                          cnt_n = cnt + 1'b1;
      end
      S_TO_CAP: begin
        st_n  = S_CAP;
        vec_n = vec + 1'b1;
      end
      S_CAP: st_n = S_TO_SHIFT;
      S_TO_SHIFT: begin
        cnt_n = '0;
        st_n  = (vec == VW'(NUM_VEC)) ? S_UNLOAD : S_LOAD;
      end
      S_UNLOAD: begin
        if (cnt == CW'(CHAIN_LEN - 1)) st_n = S_EXIT;
        else                          cnt_n = cnt + 1'b1;
      end
      S_EXIT:  st_n = S_DONE;
      default: st_n = S_IDLE;
    endcase
  end

  // Output decode of the phase about to be entered (outputs are registered)
  always_comb begin
    mode_n   = 1'b0;
    sce_n    = 1'b0;
    sys_n    = 1'b0;
    si_n     = 1'b0;
    cap_n    = 1'b0;
    chk_n    = 1'b0;
    exp_n    = 1'b0;
    integ_ph = cnt_n[1:0] - LMOD;
    case (st_n)
      S_ENTER, S_TO_SHIFT: mode_n = 1'b1;
      S_INTEG: begin
        mode_n = 1'b1;
        sce_n  = 1'b1;
        si_n   = cnt_n[1];
        chk_n  = (cnt_n >= CW'(CHAIN_LEN));
        exp_n  = (integ_ph >= 2'd2);
      end
      S_LOAD: begin
        mode_n = 1'b1;
        sce_n  = 1'b1;
        si_n   = stim_data[cnt_n[IW-1:0]];
        chk_n  = 1'b1;
        exp_n  = (vec_n == '0) ? cnt_n[1] : resp_data[cnt_n[IW-1:0]];
      end
      S_CAP: begin
        sce_n = 1'b1;
        sys_n = 1'b1;
        cap_n = 1'b1;
      end
      S_UNLOAD: begin
        mode_n = 1'b1;
        sce_n  = 1'b1;
        chk_n  = 1'b1;
        exp_n  = resp_data[cnt_n[IW-1:0]];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt         <= '0;
      vec         <= '0;
      test_mode   <= 1'b0;
      scan_clk_en <= 1'b0;
      sys_clk_en  <= 1'b0;
      chain_si    <= 1'b0;
      capture_stb <= 1'b0;
      cmp_en      <= 1'b0;
      cmp_bit     <= 1'b0;
      done        <= 1'b0;
    end else begin
      st          <= st_n;
      cnt         <= cnt_n;
      vec         <= vec_n;
      test_mode   <= mode_n;
      scan_clk_en <= sce_n;
      sys_clk_en  <= sys_n;
      chain_si    <= si_n;
      capture_stb <= cap_n;
      cmp_en      <= chk_n;
      cmp_bit     <= exp_n;
      done        <= (st_n == S_DONE);
    end
  end

  // Pulse tally used only by the budget assertion
  logic [PCW-1:0] pulse_cnt;
  always_ff @(posedge clk) begin
    if (rst || run_clr)                pulse_cnt <= '0;
    else if (scan_clk_en || sys_clk_en) pulse_cnt <= pulse_cnt + 1'b1;
  end

  p_mode_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (test_mode != $past(test_mode)) |-> (!scan_clk_en && !sys_clk_en));

  p_capture_shape_r1: assert property (@(posedge clk) disable iff (rst)
    sys_clk_en |-> (scan_clk_en && !test_mode && capture_stb));

  p_shift_shape_r1: assert property (@(posedge clk) disable iff (rst)
    (scan_clk_en && test_mode) |-> !sys_clk_en);

  p_clock_budget_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXIT) |-> (pulse_cnt == PCW'(BUDGET)));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

endmodule

// File: rtl/pscan_resp_chk.sv
module pscan_resp_chk (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic publish,
  input  logic shift_en,
  input  logic cmp_en,
  input  logic cmp_bit,
  input  logic chain_so,
  output logic mismatch
);

  logic err;
  logic bad_bit;

  assign bad_bit = shift_en && cmp_en && (chain_so != cmp_bit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err      <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      if (bad_bit) err <= 1'b1;
      if (publish) mismatch <= err;
    end
  end

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err);

  p_clear_on_start_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!mismatch && !err));

  p_flag_needs_error_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mismatch) |-> $past(err));

endmodule

// File: rtl/pscan_seq.sv
module pscan_seq #(
  parameter int CHAIN_LEN = 12,
  parameter int NUM_VEC   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic chain_so,
  output logic test_mode,
  output logic scan_clk_en,
  output logic sys_clk_en,
  output logic chain_si,
  output logic capture_stb,
  output logic done,
  output logic mismatch
);
  import pscan_pkg::*;

  localparam int AW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [AW-1:0]        stim_addr, resp_addr;
  logic [CHAIN_LEN-1:0] stim_data, resp_data;
  logic                 cmp_en, cmp_bit, run_clr, publish;

  pscan_rom #(.WIDTH(CHAIN_LEN), .DEPTH(NUM_VEC), .KIND(ROM_STIM)) u_stim_rom (
    .clk  (clk),
    .addr (stim_addr),
    .data (stim_data)
  );

  pscan_rom #(.WIDTH(CHAIN_LEN), .DEPTH(NUM_VEC), .KIND(ROM_RESP)) u_resp_rom (
    .clk  (clk),
    .addr (resp_addr),
    .data (resp_data)
  );

  pscan_ctrl #(.CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .stim_data   (stim_data),
    .resp_data   (resp_data),
    .stim_addr   (stim_addr),
    .resp_addr   (resp_addr),
    .test_mode   (test_mode),
    .scan_clk_en (scan_clk_en),
    .sys_clk_en  (sys_clk_en),
    .chain_si    (chain_si),
    .capture_stb (capture_stb),
    .cmp_en      (cmp_en),
    .cmp_bit     (cmp_bit),
    .run_clr     (run_clr),
    .publish     (publish),
    .done        (done)
  );

  pscan_resp_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (run_clr),
    .publish  (publish),
    .shift_en (scan_clk_en),
    .cmp_en   (cmp_en),
    .cmp_bit  (cmp_bit),
    .chain_so (chain_so),
    .mismatch (mismatch)
  );

endmodule

// File: tb/tb_pscan_seq.sv
module tb_pscan_seq;
  localparam int L      = 12;
  localparam int N      = 6;
  localparam int BUDGET = (N + 2) * L + N + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic chain_so;
  logic test_mode, scan_clk_en, sys_clk_en, chain_si, capture_stb, done, mismatch;

  always #2.5 clk = ~clk;

  pscan_seq #(.CHAIN_LEN(L), .NUM_VEC(N)) dut (
    .clk(clk), .rst(rst), .start(start), .chain_so(chain_so),
    .test_mode(test_mode), .scan_clk_en(scan_clk_en), .sys_clk_en(sys_clk_en),
    .chain_si(chain_si), .capture_stb(capture_stb), .done(done), .mismatch(mismatch)
  );

  // Model of the partially scanned circuit: chain plus an unscanned counter
  logic [L-1:0] ch = '0;
  logic [L-1:0] ns = '0;
  logic ns_rst = 1'b0;
  logic flip = 1'b0;

  always @(posedge clk) begin
    if (scan_clk_en && test_mode)       ch <= {chain_si, ch[L-1:1]};
    else if (scan_clk_en && !test_mode) ch <= ~ch ^ ns;
    if (rst || ns_rst)   ns <= '0;
    else if (sys_clk_en) ns <= ns + 1'b1;
  end

  assign chain_so = ch[0] ^ flip;

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] vec_word(input int v);
    logic [31:0] w;
    w = (32'(v + 1) * 32'h9E37_79B1) ^ 32'hA5A5_A5A5;
    return w[L-1:0];
  endfunction

  function automatic bit is_capture_idx(input int p);
    int q;
    if (p < L + 4 || p >= L + 4 + N * (L + 1)) return 0;
    q = p - L - 4;
    return (q % (L + 1)) == L;
  endfunction

  function automatic bit exp_mismatch(input bit inj, input int idx);
    if (!inj || idx < L || idx >= BUDGET) return 0;
    if (is_capture_idx(idx)) return 0;
    return 1;
  endfunction

  // Monitor, sampled at the falling edge
  bit mon_on = 0;
  bit inj_on = 0;
  int inj_idx = 0;
  int pcnt, e_integ, e_load, e_unload, e_shape, e_gap;
  logic prev_mode = 1'b0;

  always @(negedge clk) begin
    flip = 1'b0;
    if (mon_on) begin
      if (test_mode != prev_mode && (scan_clk_en || sys_clk_en)) e_gap++;
      if (scan_clk_en || sys_clk_en) begin
        if (pcnt < L + 4) begin
          if (!(test_mode && scan_clk_en && !sys_clk_en)) e_shape++;
          if (chain_si != pcnt[1]) e_integ++;
        end else if (pcnt < L + 4 + N * (L + 1)) begin
          int q, v, j;
          logic [L-1:0] w;
          q = pcnt - L - 4;
          v = q / (L + 1);
          j = q % (L + 1);
          w = vec_word(v);
          if (j == L) begin
            if (!(scan_clk_en && sys_clk_en && capture_stb && !test_mode)) e_shape++;
          end else begin
            if (!(test_mode && scan_clk_en && !sys_clk_en)) e_shape++;
            if (chain_si != w[j]) e_load++;
          end
        end else begin
          if (!(test_mode && scan_clk_en && !sys_clk_en)) e_shape++;
          if (chain_si != 1'b0) e_unload++;
        end
        if (inj_on && pcnt == inj_idx) flip = 1'b1;
        pcnt++;
      end
    end
    prev_mode = test_mode;
  end

  task automatic run(input bit inj, input int idx, input bit mid_start,
                     input bit check_clear, input string tag);
    int c;
    @(negedge clk);
    pcnt = 0; e_integ = 0; e_load = 0; e_unload = 0; e_shape = 0; e_gap = 0;
    inj_on = inj; inj_idx = idx;
    start = 1'b1; ns_rst = 1'b1; mon_on = 1;
    @(negedge clk);
    start = 1'b0; ns_rst = 1'b0;
    if (check_clear) begin
      check("R9 done cleared by start", done == 1'b0, done, 0);
      check("R9 mismatch cleared by start", mismatch == 1'b0, mismatch, 0);
    end
    c = 0;
    while (!done && c < 4 * BUDGET) begin
      @(negedge clk);
      start = (mid_start && c == 30);
      c++;
    end
    start = 1'b0;
    check({"R5 run finishes ", tag}, done == 1'b1, done, 1);
    repeat (3) @(negedge clk);
    mon_on = 0;
    check({"R9 done held ", tag}, done == 1'b1, done, 1);
    check({"R5 pulse budget ", tag}, pcnt == BUDGET, pcnt, BUDGET);
    check({"R3 integrity bits ", tag}, e_integ == 0, e_integ, 0);
    check({"R4 vector bits ", tag}, e_load == 0, e_load, 0);
    check({"R6 unload bits ", tag}, e_unload == 0, e_unload, 0);
    check({"R1 enable shape ", tag}, e_shape == 0, e_shape, 0);
    check({"R2 mode quiet ", tag}, e_gap == 0, e_gap, 0);
    check({"R8 mismatch flag ", tag}, mismatch == exp_mismatch(inj, idx),
          mismatch, exp_mismatch(inj, idx));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (5) @(negedge clk);
    check("R1 reset test_mode", test_mode == 1'b0, test_mode, 0);
    check("R1 reset scan_clk_en", scan_clk_en == 1'b0, scan_clk_en, 0);
    check("R1 reset sys_clk_en", sys_clk_en == 1'b0, sys_clk_en, 0);
    check("R1 reset outputs", {chain_si, capture_stb, done, mismatch} == 4'b0,
          {chain_si, capture_stb, done, mismatch}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    run(0, 0, 0, 0, "R7 clean");
    run(1, L - 1, 0, 0, "unchecked window");
    run(1, L, 0, 0, "first checked integrity bit");
    run(1, L + 4 + L, 0, 0, "on capture");
    run(1, BUDGET - 1, 0, 0, "last unload bit");
    run(0, 0, 0, 1, "R7 clean after error");
    run(1, L + 4 + 2, 0, 0, "vector 0 load");
    run(0, 0, 1, 1, "R10 start while busy");
    for (int r = 0; r < 10; r++) begin
      bit inj;
      int idx;
      inj = ($urandom % 4) != 0;
      idx = $urandom % BUDGET;
      run(inj, idx, ($urandom % 3) == 0, 1, "random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule